// File: doc/BRIEF.md
# Complex Multiply-Accumulate Lane with Column RAM

This block is one arithmetic lane of a matrix-product engine working on complex numbers. It keeps a small set of resident complex multiplicands (the "A" operands, loaded ahead of time). Each cycle it can accept one broadcast complex operand "B" together with a column index and a selector that names which resident A to use. The lane forms the complex product from four real multiplies, one subtraction and one addition. It then adds that product into a running complex sum kept for that column in a dual-port RAM. A single lane therefore accumulates a whole row of the result, one column entry per RAM word.

The update runs as a three-stage pipeline. Stage one multiplies. Stage two combines the products into real and imaginary parts. Stage three adds the stored sum and writes the RAM. The RAM is read one stage ahead, so the stored sum is ready at the accumulate stage. The write stage forwards a sum that has not yet reached the RAM. A first-pass flag makes an update store the bare product, which removes the need for a separate clearing sweep. A readout command streams every stored sum out in increasing column order, one per cycle, with a valid strobe.

Top module: `cmac_lane`

## Requirements
- R1: An update with resident operand (ar, ai) and broadcast operand (br, bi) contributes ar*br - ai*bi to the real part and ar*bi + ai*br to the imaginary part, as signed two's-complement values.
- R2: An update presented with `b_valid` high at a rising edge appears on `upd_valid`, `upd_col`, `upd_re` and `upd_im` after the third rising edge counted from that one. `upd_col` equals the column given with the operand.
- R3: When `first_pass` is high, the column's new sum is exactly the product, whatever was stored before and whatever is still in flight for that column.
- R4: When `first_pass` is low, the column's new sum is the previous sum of that column plus the product, in both the real and the imaginary part.
- R5: Updates to the same column on consecutive cycles accumulate correctly, with no stale value read from the RAM.
- R6: Updates to the same column two cycles apart accumulate correctly.
- R7: A resident operand written through `a_load` at index k is the one used by later updates that present `a_sel` = k.
- R8: After a one-cycle `rd_start` pulse while idle, `rd_valid` rises after the second rising edge. It then stays high for DEPTH consecutive cycles, with `rd_col` going 0, 1, ... DEPTH-1 and `rd_re`/`rd_im` equal to the stored sums of those columns.
- R9: While and just after reset, `upd_valid` and `rd_valid` are low.
- R10: A cycle with `b_valid` low produces no `upd_valid` pulse three cycles later and leaves every stored sum unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| a_load | input | 1 | Write a resident operand this cycle |
| a_load_idx | input | SEL_W | Slot that the resident operand is written to |
| a_load_re | input | DW | Real part of the operand being loaded |
| a_load_im | input | DW | Imaginary part of the operand being loaded |
| b_valid | input | 1 | A broadcast operand is present |
| b_re | input | DW | Real part of the broadcast operand |
| b_im | input | DW | Imaginary part of the broadcast operand |
| b_col | input | COL_W | Column whose sum is updated |
| a_sel | input | SEL_W | Resident operand slot used for this update |
| first_pass | input | 1 | Store the product without adding the old sum |
| rd_start | input | 1 | Begin streaming out all stored sums |
| upd_valid | output | 1 | An updated sum is presented |
| upd_col | output | COL_W | Column of the updated sum |
| upd_re | output | AW | Real part of the updated sum |
| upd_im | output | AW | Imaginary part of the updated sum |
| rd_valid | output | 1 | A streamed sum is presented |
| rd_col | output | COL_W | Column of the streamed sum |
| rd_re | output | AW | Real part of the streamed sum |
| rd_im | output | AW | Imaginary part of the streamed sum |

## Verification
The properties assume the lane is used in one mode at a time. `rd_start` is pulsed only while no update is in the pipeline and no readout is running, and `b_valid` stays low from that pulse until the last streamed column. They also take it that a resident slot is not reloaded in the same cycle it is selected. The stimulus keeps to these rules. It clears every column with a first-pass sweep, then drains the pipeline for several idle cycles before the checked update sequence starts. It drains again before the readout pulse and leaves all operand loads to the setup phase.

// File: rtl/cmac_pkg.sv
package cmac_pkg;
    // Default sizing of one lane
    localparam int CMAC_DW    = 16;
    localparam int CMAC_AW    = 40;
    localparam int CMAC_DEPTH = 64;
    localparam int CMAC_NUM_A = 4;

    // Readout sequencer state
    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RUN  = 1'b1
    } rd_state_e;
endpackage

// File: rtl/cmac_cmul.sv
// Four real products of a complex multiply; purely combinational.
module cmac_cmul #(
    parameter int DW = cmac_pkg::CMAC_DW,
    localparam int PW = 2 * DW
) (
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    output logic signed [PW-1:0] p_rr,
    output logic signed [PW-1:0] p_ii,
    output logic signed [PW-1:0] p_ri,
    output logic signed [PW-1:0] p_ir
);
    logic signed [DW-1:0] lhs [4];
    logic signed [DW-1:0] rhs [4];
    logic signed [PW-1:0] prod [4];

    // operand pairing: rr, ii, ri, ir
    assign lhs[0] = a_re; assign rhs[0] = b_re;
    assign lhs[1] = a_im; assign rhs[1] = b_im;
    assign lhs[2] = a_re; assign rhs[2] = b_im;
    assign lhs[3] = a_im; assign rhs[3] = b_re;

    for (genvar g = 0; g < 4; g++) begin : g_mul
        assign prod[g] = lhs[g] * rhs[g];
    end

    assign p_rr = prod[0];
    assign p_ii = prod[1];
    assign p_ri = prod[2];
    assign p_ir = prod[3];
endmodule

// File: rtl/cmac_acc_ram.sv
// Column sum storage: one write port, one registered read port.
// A read and a write of the same word at one edge returns the old word.
module cmac_acc_ram #(
    parameter int AW    = cmac_pkg::CMAC_AW,
    parameter int DEPTH = cmac_pkg::CMAC_DEPTH,
    localparam int CW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [CW-1:0]        waddr,
    input  logic signed [AW-1:0] wre,
    input  logic signed [AW-1:0] wim,
    input  logic [CW-1:0]        raddr,
    output logic signed [AW-1:0] rre,
    output logic signed [AW-1:0] rim
);
    logic [2*AW-1:0] mem [DEPTH];
    logic [2*AW-1:0] rword_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= {wre, wim};
        end
        rword_q <= mem[raddr];
    end

    assign rre = $signed(rword_q[2*AW-1:AW]);
    assign rim = $signed(rword_q[AW-1:0]);
endmodule

// File: rtl/cmac_rdseq.sv
// Walks every column once after a start pulse; output timing matches RAM read latency.
module cmac_rdseq #(
    parameter int DEPTH = cmac_pkg::CMAC_DEPTH,
    localparam int CW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_start,
    output logic          rd_busy,
    output logic [CW-1:0] rd_addr,
    output logic          rd_valid,
    output logic [CW-1:0] rd_col
);
    import cmac_pkg::*;

    localparam logic [CW-1:0] LAST_COL = CW'(DEPTH - 1);

    typedef struct packed {
        rd_state_e     st;
        logic [CW-1:0] ptr;
        logic          ovld;
        logic [CW-1:0] ocol;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.ovld = (seq_q.st == RD_RUN);
        seq_d.ocol = seq_q.ptr;
        if (seq_q.st == RD_RUN) begin
            if (seq_q.ptr == LAST_COL) begin
                seq_d.st  = RD_IDLE;
                seq_d.ptr = '0;
            end else begin
                seq_d.ptr = seq_q.ptr + 1'b1;
            end
        end else if (rd_start) begin
            seq_d.st  = RD_RUN;
            seq_d.ptr = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rd_busy  = (seq_q.st == RD_RUN);
    assign rd_addr  = seq_q.ptr;
    assign rd_valid = seq_q.ovld;
    assign rd_col   = seq_q.ocol;
endmodule

// File: rtl/cmac_lane.sv
// One complex multiply-accumulate lane with per-column sums in RAM.
module cmac_lane #(
    parameter int DW    = cmac_pkg::CMAC_DW,
    parameter int AW    = cmac_pkg::CMAC_AW,
    parameter int DEPTH = cmac_pkg::CMAC_DEPTH,
    parameter int NUM_A = cmac_pkg::CMAC_NUM_A,
    localparam int COL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int SEL_W = (NUM_A > 1) ? $clog2(NUM_A) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 a_load,
    input  logic [SEL_W-1:0]     a_load_idx,
    input  logic signed [DW-1:0] a_load_re,
    input  logic signed [DW-1:0] a_load_im,
    input  logic                 b_valid,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    input  logic [COL_W-1:0]     b_col,
    input  logic [SEL_W-1:0]     a_sel,
    input  logic                 first_pass,
    input  logic                 rd_start,
    output logic                 upd_valid,
    output logic [COL_W-1:0]     upd_col,
    output logic signed [AW-1:0] upd_re,
    output logic signed [AW-1:0] upd_im,
    output logic                 rd_valid,
    output logic [COL_W-1:0]     rd_col,
    output logic signed [AW-1:0] rd_re,
    output logic signed [AW-1:0] rd_im
);
    localparam int PW = 2 * DW;   // one real product
    localparam int SW = PW + 1;   // combined real or imaginary part

    typedef struct packed {
        logic signed [DW-1:0] re;
        logic signed [DW-1:0] im;
    } cpx_t;

    typedef struct packed {
        logic                 vld;
        logic                 first;
        logic [COL_W-1:0]     col;
        logic signed [PW-1:0] p_rr;
        logic signed [PW-1:0] p_ii;
        logic signed [PW-1:0] p_ri;
        logic signed [PW-1:0] p_ir;
    } mul_stage_t;

    typedef struct packed {
        logic                 vld;
        logic                 first;
        logic [COL_W-1:0]     col;
        logic signed [SW-1:0] c_re;
        logic signed [SW-1:0] c_im;
    } cmb_stage_t;

    typedef struct packed {
        logic                 vld;
        logic [COL_W-1:0]     col;
        logic signed [AW-1:0] s_re;
        logic signed [AW-1:0] s_im;
    } acc_stage_t;

    typedef struct packed {
        cpx_t [NUM_A-1:0] a;
        mul_stage_t       m;
        cmb_stage_t       c;
        acc_stage_t       w;
    } lane_t;

    lane_t lane_d, lane_q;

    // multiplier outputs
    cpx_t                 a_cur;
    logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;

    // RAM and readout interface
    logic                 rd_busy;
    logic [COL_W-1:0]     rd_addr;
    logic [COL_W-1:0]     ram_raddr;
    logic signed [AW-1:0] ram_rre, ram_rim;
    logic signed [AW-1:0] old_re, old_im;
    logic signed [AW-1:0] sum_re, sum_im;

    assign a_cur = lane_q.a[a_sel];

    cmac_cmul #(.DW(DW)) mul_i (
        .a_re (a_cur.re),
        .a_im (a_cur.im),
        .b_re (b_re),
        .b_im (b_im),
        .p_rr (p_rr),
        .p_ii (p_ii),
        .p_ri (p_ri),
        .p_ir (p_ir)
    );

    always_comb begin
        lane_d = lane_q;

        if (a_load) begin
            lane_d.a[a_load_idx].re = a_load_re;
            lane_d.a[a_load_idx].im = a_load_im;
        end

        // stage 1: register the four real products
        lane_d.m.vld   = b_valid;
        lane_d.m.first = first_pass;
        lane_d.m.col   = b_col;
        lane_d.m.p_rr  = p_rr;
        lane_d.m.p_ii  = p_ii;
        lane_d.m.p_ri  = p_ri;
        lane_d.m.p_ir  = p_ir;

        // stage 2: real = rr - ii, imaginary = ri + ir
        lane_d.c.vld   = lane_q.m.vld;
        lane_d.c.first = lane_q.m.first;
        lane_d.c.col   = lane_q.m.col;
        lane_d.c.c_re  = SW'(lane_q.m.p_rr) - SW'(lane_q.m.p_ii);
        lane_d.c.c_im  = SW'(lane_q.m.p_ri) + SW'(lane_q.m.p_ir);

        // stage 3: pick old sum (forward from the write stage if it targets this column)
        if (lane_q.w.vld && (lane_q.w.col == lane_q.c.col)) begin
            old_re = lane_q.w.s_re;
            old_im = lane_q.w.s_im;
        end else begin
            old_re = ram_rre;
            old_im = ram_rim;
        end
        if (lane_q.c.first) begin
            sum_re = AW'(lane_q.c.c_re);
            sum_im = AW'(lane_q.c.c_im);
        end else begin
            sum_re = old_re + AW'(lane_q.c.c_re);
            sum_im = old_im + AW'(lane_q.c.c_im);
        end
        lane_d.w.vld  = lane_q.c.vld;
        lane_d.w.col  = lane_q.c.col;
        lane_d.w.s_re = sum_re;
        lane_d.w.s_im = sum_im;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    // read one stage early for updates; the sequencer owns the port during readout
    assign ram_raddr = rd_busy ? rd_addr : lane_q.m.col;

    cmac_acc_ram #(.AW(AW), .DEPTH(DEPTH)) ram_i (
        .clk   (clk),
        .we    (lane_q.c.vld),
        .waddr (lane_q.c.col),
        .wre   (sum_re),
        .wim   (sum_im),
        .raddr (ram_raddr),
        .rre   (ram_rre),
        .rim   (ram_rim)
    );

    cmac_rdseq #(.DEPTH(DEPTH)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_start (rd_start),
        .rd_busy  (rd_busy),
        .rd_addr  (rd_addr),
        .rd_valid (rd_valid),
        .rd_col   (rd_col)
    );

    assign upd_valid = lane_q.w.vld;
    assign upd_col   = lane_q.w.col;
    assign upd_re    = lane_q.w.s_re;
    assign upd_im    = lane_q.w.s_im;
    assign rd_re     = ram_rre;
    assign rd_im     = ram_rim;
endmodule

// File: rtl/cmac_lane_chk.sv
module cmac_lane_chk #(
    parameter int DEPTH = cmac_pkg::CMAC_DEPTH,
    localparam int CW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          b_valid,
    input logic [CW-1:0] b_col,
    input logic          rd_start,
    input logic          upd_valid,
    input logic [CW-1:0] upd_col,
    input logic          rd_valid,
    input logic [CW-1:0] rd_col
);
    // R2
    upd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid |-> ##3 upd_valid);

    // R2
    upd_column_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid |-> ##3 (upd_col == $past(b_col, 3)));

    // R10
    idle_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !b_valid |-> ##3 !upd_valid);

    // R8
    rd_first_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && !rd_valid) |-> ##2 (rd_valid && rd_col == '0));

    // R8
    rd_ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rd_valid)) |-> (rd_col == CW'($past(rd_col) + 1'b1)));

    // R8
    rd_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_col == CW'(DEPTH - 1)) |=> !rd_valid);
endmodule

bind cmac_lane cmac_lane_chk #(.DEPTH(DEPTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .b_valid   (b_valid),
    .b_col     (b_col),
    .rd_start  (rd_start),
    .upd_valid (upd_valid),
    .upd_col   (upd_col),
    .rd_valid  (rd_valid),
    .rd_col    (rd_col)
);

// File: tb/cmac_lane_tb_top.sv
`timescale 1ns/1ps
module cmac_lane_tb_top;
    localparam int DW    = 16;
    localparam int AW    = 40;
    localparam int DEPTH = 64;
    localparam int NUM_A = 4;
    localparam int CW    = $clog2(DEPTH);
    localparam int SW    = $clog2(NUM_A);
    localparam int NV    = 10;

    typedef struct packed {
        logic        fp;
        logic [1:0]  sel;
        logic [5:0]  col;
        int          br;
        int          bi;
        int          er;
        int          ei;
    } vec_t;

    // resident A0 = (3,-2), A1 = (1,4); expected column sums after each update
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd0, 6'd5,       1,      1,     5,       1},  // R1 R3
        '{1'b0, 2'd0, 6'd5,       2,      0,    11,      -3},  // R4 R5
        '{1'b1, 2'd1, 6'd7,       2,     -1,     6,       7},  // R7
        '{1'b0, 2'd1, 6'd5,      -3,      2,     0,     -13},  // R6
        '{1'b0, 2'd0, 6'd7,       0,      5,    16,      22},  // R6
        '{1'b1, 2'd0, 6'd5,       4,      4,    20,       4},  // R3
        '{1'b0, 2'd1, 6'd5,      -1,     -1,    23,      -1},  // R5
        '{1'b0, 2'd1, 6'd5,    1000,  -1000,  5023,    2999},  // R5
        '{1'b1, 2'd1, 6'd0,  -32768, -32768, 98304, -163840},  // R1
        '{1'b1, 2'd0, 6'd63,  32767, -32768, 32765, -163838}   // R1
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 a_load = 1'b0;
    logic [SW-1:0]        a_load_idx = '0;
    logic signed [DW-1:0] a_load_re = '0, a_load_im = '0;
    logic                 b_valid = 1'b0;
    logic signed [DW-1:0] b_re = '0, b_im = '0;
    logic [CW-1:0]        b_col = '0;
    logic [SW-1:0]        a_sel = '0;
    logic                 first_pass = 1'b0;
    logic                 rd_start = 1'b0;
    logic                 upd_valid;
    logic [CW-1:0]        upd_col;
    logic signed [AW-1:0] upd_re, upd_im;
    logic                 rd_valid;
    logic [CW-1:0]        rd_col;
    logic signed [AW-1:0] rd_re, rd_im;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int mon_idx = 0;
    bit mon_en = 1'b0;
    int drive_cyc [NV];
    longint sh_re [DEPTH];
    longint sh_im [DEPTH];

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    cmac_lane #(.DW(DW), .AW(AW), .DEPTH(DEPTH), .NUM_A(NUM_A)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_load(a_load), .a_load_idx(a_load_idx), .a_load_re(a_load_re), .a_load_im(a_load_im),
        .b_valid(b_valid), .b_re(b_re), .b_im(b_im), .b_col(b_col), .a_sel(a_sel),
        .first_pass(first_pass), .rd_start(rd_start),
        .upd_valid(upd_valid), .upd_col(upd_col), .upd_re(upd_re), .upd_im(upd_im),
        .rd_valid(rd_valid), .rd_col(rd_col), .rd_re(rd_re), .rd_im(rd_im)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // update monitor: every upd pulse must match the next table entry, in its cycle
    always @(negedge clk) begin
        if (mon_en && upd_valid) begin
            if (mon_idx >= NV) begin
                chk(1'b0, "R10 unexpected update", longint'(upd_col), -1);
            end else begin
                chk(cyc == drive_cyc[mon_idx] + 3, "R2 latency", cyc, drive_cyc[mon_idx] + 3);
                chk(upd_col == VEC[mon_idx].col, "R2 column", upd_col, VEC[mon_idx].col);
                chk(upd_re == AW'(VEC[mon_idx].er), "R1/R4 real sum", upd_re, VEC[mon_idx].er);
                chk(upd_im == AW'(VEC[mon_idx].ei), "R1/R4 imag sum", upd_im, VEC[mon_idx].ei);
            end
            mon_idx++;
        end
    end

    initial begin
        #(200000 * 8);
        chk(1'b0, "watchdog", cyc, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: outputs quiet in reset
        chk(upd_valid == 1'b0, "R9 upd_valid in reset", upd_valid, 0);
        chk(rd_valid == 1'b0, "R9 rd_valid in reset", rd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(upd_valid == 1'b0 && rd_valid == 1'b0, "R9 after reset", {upd_valid, rd_valid}, 0);

        // R7: load resident operands
        a_load = 1'b1;
        a_load_idx = 2'd0; a_load_re = 16'sd3; a_load_im = -16'sd2;
        @(negedge clk);
        a_load_idx = 2'd1; a_load_re = 16'sd1; a_load_im = 16'sd4;
        @(negedge clk);
        a_load = 1'b0;

        // clear sweep with first-pass zero products
        for (int c = 0; c < DEPTH; c++) begin
            b_valid = 1'b1; first_pass = 1'b1; a_sel = 2'd0;
            b_col = CW'(c); b_re = '0; b_im = '0;
            sh_re[c] = 0; sh_im[c] = 0;
            @(negedge clk);
        end
        b_valid = 1'b0; first_pass = 1'b0;
        repeat (5) @(negedge clk);
        mon_en = 1'b1;

        // table of checked updates, back to back
        for (int i = 0; i < NV; i++) begin
            b_valid    = 1'b1;
            first_pass = VEC[i].fp;
            a_sel      = VEC[i].sel;
            b_col      = VEC[i].col;
            b_re       = DW'(VEC[i].br);
            b_im       = DW'(VEC[i].bi);
            drive_cyc[i] = cyc;
            sh_re[VEC[i].col] = VEC[i].er;
            sh_im[VEC[i].col] = VEC[i].ei;
            @(negedge clk);
        end
        b_valid = 1'b0; first_pass = 1'b0;
        // R10: idle cycles with junk operands must not create updates
        b_re = 16'sd777; b_im = -16'sd555; b_col = 6'd9;
        repeat (6) @(negedge clk);
        chk(mon_idx == NV, "R2/R10 update count", mon_idx, NV);

        // R8: readout of every column
        rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        chk(rd_valid == 1'b0, "R8 not yet valid", rd_valid, 0);
        @(negedge clk);
        for (int k = 0; k < DEPTH; k++) begin
            chk(rd_valid == 1'b1, "R8 valid run", rd_valid, 1);
            chk(rd_col == CW'(k), "R8 column order", rd_col, k);
            chk(rd_re == AW'(sh_re[k]) && rd_im == AW'(sh_im[k]),
                "R8 R10 stored sum (real)", rd_re, sh_re[k]);
            @(negedge clk);
        end
        chk(rd_valid == 1'b0, "R8 run length", rd_valid, 0);
        repeat (2) @(negedge clk);
        summary();
    end
endmodule